// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Selectable Write Policy

This block sits between a processor's word-wide load/store port and a slower word-wide memory. It keeps a small direct-mapped cache of multi-word lines. Each line holds a valid bit, a dirty bit, a tag and its data words. Two build-time parameters choose the write policy:

- The update policy is either write-through or write-back.
- The allocation policy is either allocate-on-write or no-allocate-on-write.

A hit is served in the cycle it is presented. Every word bound for memory passes through a small first-in, first-out buffer made of registers. This covers write-through stores, stores that miss without allocation and dirty victims. Because of the buffer, the processor does not wait on memory for these writes.

A miss raises the stall signal. The block then performs these steps in order:

1. It pushes a dirty victim into the buffer.
2. It waits until no buffered word belongs to the missing line.
3. It fetches the line one word at a time.
4. It completes the request as a hit.

The processor must hold its request stable while the stall signal is high. The buffer uses the memory port whenever a line fetch is not using it.

Top module: `wpol_cache`

## Requirements
- R1: A read that hits, and a write that hits and needs no buffer slot, completes in the cycle it is presented. `cpu_stall` stays low in that cycle, and `cpu_rdata` carries the addressed word in the same cycle.
- R2: Write-through mode (`WRITE_BACK`=0): a write hit updates the cached word and puts the word into the buffer. `wb_empty` is low on the following cycle.
- R3: Write-through mode: replacing a line never produces a memory write.
- R4: Write-back mode (`WRITE_BACK`=1): a write hit updates only the cached word and marks the line dirty. It creates no buffer entry and no memory write.
- R5: Write-back mode: when the line being replaced is dirty, all `LINE_WORDS` of its words enter the buffer before the fetch starts, and they reach memory. A clean line being replaced is overwritten with no memory write.
- R6: Allocate-on-write (`WRITE_ALLOC`=1): both read misses and write misses fetch the whole line from memory. The request then completes as a hit.
- R7: No-allocate-on-write (`WRITE_ALLOC`=0): a write miss only places the word in the buffer and does not touch the cache. Read misses still fetch the line.
- R8: A miss does not start its fetch while any buffered word belongs to the missing line. A read therefore returns the newest value written.
- R9: A processor write that needs a buffer slot stalls while the buffer is full. `wb_full` is high exactly when all `WB_DEPTH` slots are used.
- R10: The buffer writes its words to memory in the order they were pushed, whenever a line fetch is not using the memory port.
- R11: Memory port protocol:
  - `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged from the cycle a request is raised until the cycle `mem_ack` is high.
  - Each transaction moves one word.
  - Read data is taken in the `mem_ack` cycle.
- R12: After synchronous reset, all lines are invalid and the buffer is empty. `wb_empty` is 1, `wb_full` is 0, and the first access is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when the request is not stalled |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Transaction completes this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| wb_empty | output | 1 | Buffer holds no words |
| wb_full | output | 1 | Buffer holds WB_DEPTH words |

## Verification
The embedded properties check several rules on every cycle:

- Read hits never stall.
- Write-through hits and non-allocating write misses always leave a word buffered.
- The buffer is never pushed when full or popped when empty.
- A line fetch never runs while a buffered word of that line is pending.
- The memory request holds stable until acknowledged.

Only the directed scenarios can show the following, because each needs memory contents or write counts observed over a whole sequence:

- A dirty victim reaches memory while a clean one does not.
- A write-back hit leaves memory untouched.
- Buffered words land in push order.
- A read right after a non-allocating write returns the new value.

// File: rtl/wpol_pkg.sv
package wpol_pkg;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // serve hits, detect misses
        ST_EVICT = 2'd1,   // push dirty victim words into the buffer
        ST_WAIT  = 2'd2,   // hold until buffer has no word of the missing line
        ST_FILL  = 2'd3    // fetch the line word by word
    } ctl_state_e;

    // Per-cycle action set produced by the controller
    typedef struct packed {
        logic served;      // processor request completes this cycle
        logic push_cpu;    // processor word enters the buffer
        logic push_evict;  // victim word enters the buffer
        logic wr_cpu;      // processor word written into the line
        logic set_dirty;   // mark line dirty
        logic fill_wr;     // fetched word written into the line
        logic inval;       // clear line valid before fetch
        logic install;     // set tag and valid after fetch
    } ctl_act_t;

    // Slot index wrap for a circular buffer
    function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
        return (p + 1 >= depth) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/wpol_store.sv
module wpol_store #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 16,
    parameter int SETS       = 8,
    parameter int LINE_WORDS = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [$clog2(SETS)-1:0]                idx,
    input  logic [ADDR_W-$clog2(SETS)-$clog2(LINE_WORDS)-1:0] tag,
    input  logic [$clog2(LINE_WORDS)-1:0]          rd_off,
    input  logic [$clog2(LINE_WORDS)-1:0]          vic_off,
    input  logic                                   wr_en,
    input  logic [$clog2(LINE_WORDS)-1:0]          wr_off,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic                                   set_dirty,
    input  logic                                   inval_en,
    input  logic                                   inst_en,
    output logic                                   hit,
    output logic                                   vic_dirty,
    output logic [ADDR_W-$clog2(SETS)-$clog2(LINE_WORDS)-1:0] vic_tag,
    output logic [DATA_W-1:0]                      rd_word,
    output logic [DATA_W-1:0]                      vic_word
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS][LINE_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                tag_q[s] <= '0;
                for (int w = 0; w < LINE_WORDS; w++) begin
                    data_q[s][w] <= '0;
                end
            end
        end else begin
            if (inval_en) begin
                valid_q[idx] <= 1'b0;
            end
            if (inst_en) begin
                valid_q[idx] <= 1'b1;
                tag_q[idx]   <= tag;
                dirty_q[idx] <= 1'b0;
            end
            if (set_dirty) begin
                dirty_q[idx] <= 1'b1;
            end
            if (wr_en) begin
                data_q[idx][wr_off] <= wr_data;
            end
        end
    end

    assign hit       = valid_q[idx] && (tag_q[idx] == tag);
    assign vic_dirty = valid_q[idx] && dirty_q[idx];
    assign vic_tag   = tag_q[idx];
    assign rd_word   = data_q[idx][rd_off];
    assign vic_word  = data_q[idx][vic_off];

endmodule

// File: rtl/wpol_wbuf.sv
module wpol_wbuf #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int OFF_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push,
    input  logic [ADDR_W-1:0]       push_addr,
    input  logic [DATA_W-1:0]       push_data,
    input  logic                    pop,
    input  logic [ADDR_W-OFF_W-1:0] probe_blk,
    output logic                    probe_hit,
    output logic [ADDR_W-1:0]       head_addr,
    output logic [DATA_W-1:0]       head_data,
    output logic                    empty,
    output logic                    full
);
    import wpol_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [PW-1:0]     wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]     cnt_q;
    logic [DEPTH-1:0]  blk_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                addr_q[e] <= '0;
                data_q[e] <= '0;
            end
        end else begin
            if (push) begin
                addr_q[wr_ptr_q] <= push_addr;
                data_q[wr_ptr_q] <= push_data;
                vld_q[wr_ptr_q]  <= 1'b1;
                wr_ptr_q         <= PW'(wrap_inc(int'(wr_ptr_q), DEPTH));
            end
            if (pop) begin
                vld_q[rd_ptr_q] <= 1'b0;
                rd_ptr_q        <= PW'(wrap_inc(int'(rd_ptr_q), DEPTH));
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // One block comparator per slot
    for (genvar e = 0; e < DEPTH; e++) begin : g_probe
        assign blk_match[e] = vld_q[e] && (addr_q[e][ADDR_W-1:OFF_W] == probe_blk);
    end

    assign probe_hit = |blk_match;
    assign head_addr = addr_q[rd_ptr_q];
    assign head_data = data_q[rd_ptr_q];
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CW'(DEPTH));

    // R9
    wb_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R10
    wb_no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/wpol_ctrl.sv
module wpol_ctrl #(
    parameter int LINE_WORDS  = 4,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic                          hit,
    input  logic                          vic_dirty,
    input  logic                          wb_full,
    input  logic                          wb_empty,
    input  logic                          wb_blk_hit,
    input  logic                          mem_ack,
    output wpol_pkg::ctl_state_e          state,
    output logic [$clog2(LINE_WORDS)-1:0] word_cnt,
    output wpol_pkg::ctl_act_t            act,
    output logic                          stall
);
    import wpol_pkg::*;

    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam logic [OFF_W-1:0] LAST_W = OFF_W'(LINE_WORDS - 1);

    ctl_state_e       st_q, st_n;
    logic [OFF_W-1:0] cnt_q, cnt_n;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        act   = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        if (!cpu_we) begin
                            act.served = 1'b1;
                        end else if (WRITE_BACK) begin
                            act.served    = 1'b1;
                            act.wr_cpu    = 1'b1;
                            act.set_dirty = 1'b1;
                        end else if (!wb_full) begin
                            act.served   = 1'b1;
                            act.wr_cpu   = 1'b1;
                            act.push_cpu = 1'b1;
                        end
                    end else if (cpu_we && !WRITE_ALLOC) begin
                        if (!wb_full) begin
                            act.served   = 1'b1;
                            act.push_cpu = 1'b1;
                        end
                    end else begin
                        cnt_n = '0;
                        st_n  = (WRITE_BACK && vic_dirty) ? ST_EVICT : ST_WAIT;
                    end
                end
            end
            ST_EVICT: begin
                if (!wb_full) begin
                    act.push_evict = 1'b1;
                    cnt_n          = cnt_q + 1'b1;
                    if (cnt_q == LAST_W) begin
                        cnt_n = '0;
                        st_n  = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                // port is free once the buffer is empty or its current word completes
                if (!wb_blk_hit && (wb_empty || mem_ack)) begin
                    act.inval = 1'b1;
                    cnt_n     = '0;
                    st_n      = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    act.fill_wr = 1'b1;
                    cnt_n       = cnt_q + 1'b1;
                    if (cnt_q == LAST_W) begin
                        act.install = 1'b1;
                        cnt_n       = '0;
                        st_n        = ST_IDLE;
                    end
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign state    = st_q;
    assign word_cnt = cnt_q;
    assign stall    = cpu_req && !act.served;

    // R1
    read_hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && cpu_req && !cpu_we && hit) |-> !stall);

    // R8
    fill_no_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FILL) |-> !wb_blk_hit);

endmodule

// File: rtl/wpol_cache.sv
module wpol_cache #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 16,
    parameter int SETS        = 8,
    parameter int LINE_WORDS  = 4,
    parameter int WB_DEPTH    = 4,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_empty,
    output logic              wb_full
);
    import wpol_pkg::*;

    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W = ADDR_W - OFF_W;

    // Address fields of the processor request
    logic [OFF_W-1:0] req_off;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic [BLK_W-1:0] req_blk;

    assign req_off = cpu_addr[OFF_W-1:0];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_blk = cpu_addr[ADDR_W-1:OFF_W];

    ctl_state_e       state;
    ctl_act_t         act;
    logic [OFF_W-1:0] word_cnt;
    logic             hit, vic_dirty, wb_blk_hit;
    logic [TAG_W-1:0] vic_tag;
    logic [DATA_W-1:0] vic_word;
    logic             fill_active;

    // Line storage write port: processor word or fetched word
    logic              st_wr_en;
    logic [OFF_W-1:0]  st_wr_off;
    logic [DATA_W-1:0] st_wr_data;

    assign st_wr_en   = act.wr_cpu | act.fill_wr;
    assign st_wr_off  = act.fill_wr ? word_cnt  : req_off;
    assign st_wr_data = act.fill_wr ? mem_rdata : cpu_wdata;

    wpol_store #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SETS       (SETS),
        .LINE_WORDS (LINE_WORDS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .idx       (req_idx),
        .tag       (req_tag),
        .rd_off    (req_off),
        .vic_off   (word_cnt),
        .wr_en     (st_wr_en),
        .wr_off    (st_wr_off),
        .wr_data   (st_wr_data),
        .set_dirty (act.set_dirty),
        .inval_en  (act.inval),
        .inst_en   (act.install),
        .hit       (hit),
        .vic_dirty (vic_dirty),
        .vic_tag   (vic_tag),
        .rd_word   (cpu_rdata),
        .vic_word  (vic_word)
    );

    // Buffer push source: victim word or processor word
    logic              wb_push, wb_pop;
    logic [ADDR_W-1:0] wb_push_addr, wb_head_addr;
    logic [DATA_W-1:0] wb_push_data, wb_head_data;

    assign wb_push      = act.push_cpu | act.push_evict;
    assign wb_push_addr = act.push_evict ? {vic_tag, req_idx, word_cnt} : cpu_addr;
    assign wb_push_data = act.push_evict ? vic_word : cpu_wdata;
    assign wb_pop       = !fill_active && !wb_empty && mem_ack;

    wpol_wbuf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (WB_DEPTH),
        .OFF_W  (OFF_W)
    ) u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .push      (wb_push),
        .push_addr (wb_push_addr),
        .push_data (wb_push_data),
        .pop       (wb_pop),
        .probe_blk (req_blk),
        .probe_hit (wb_blk_hit),
        .head_addr (wb_head_addr),
        .head_data (wb_head_data),
        .empty     (wb_empty),
        .full      (wb_full)
    );

    wpol_ctrl #(
        .LINE_WORDS  (LINE_WORDS),
        .WRITE_BACK  (WRITE_BACK),
        .WRITE_ALLOC (WRITE_ALLOC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .hit        (hit),
        .vic_dirty  (vic_dirty),
        .wb_full    (wb_full),
        .wb_empty   (wb_empty),
        .wb_blk_hit (wb_blk_hit),
        .mem_ack    (mem_ack),
        .state      (state),
        .word_cnt   (word_cnt),
        .act        (act),
        .stall      (cpu_stall)
    );

    // Memory port: line fetch owns it in ST_FILL, otherwise the buffer drains
    assign fill_active = (state == ST_FILL);
    assign mem_req     = fill_active || !wb_empty;
    assign mem_we      = !fill_active;
    assign mem_addr    = fill_active ? {req_blk, word_cnt} : wb_head_addr;
    assign mem_wdata   = wb_head_data;

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R2
    wt_hit_buffered_chk: assert property (@(posedge clk) disable iff (rst)
        (!WRITE_BACK && cpu_req && cpu_we && hit && !cpu_stall) |=> !wb_empty);

    // R7
    nwa_miss_buffered_chk: assert property (@(posedge clk) disable iff (rst)
        (!WRITE_ALLOC && cpu_req && cpu_we && !hit && !cpu_stall) |=> !wb_empty);

endmodule

// File: tb/wpol_cache_test.sv
`timescale 1ns/1ps

module wpol_cache_memsim #(
    parameter int AW  = 12,
    parameter int DW  = 16,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [2**AW];
    logic [AW-1:0] log_addr [64];
    int            wr_count;
    int            hold_err;
    int            wait_q;
    logic          pend_q;
    logic [AW-1:0] pa_q;
    logic          pw_q;
    logic [DW-1:0] pd_q;

    initial begin
        for (int i = 0; i < 2**AW; i++) mem[i] = DW'(i * 7 + 3);
    end

    assign ack   = req && (wait_q == LAT);
    assign rdata = mem[addr];

    always @(posedge clk) begin
        if (rst) begin
            wait_q   <= 0;
            wr_count <= 0;
            hold_err <= 0;
            pend_q   <= 1'b0;
        end else begin
            if (pend_q && (!req || addr != pa_q || we != pw_q || (we && wdata != pd_q)))
                hold_err <= hold_err + 1;
            pend_q <= req && !ack;
            pa_q   <= addr;
            pw_q   <= we;
            pd_q   <= wdata;
            if (req) begin
                if (ack) begin
                    wait_q <= 0;
                    if (we) begin
                        mem[addr] <= wdata;
                        if (wr_count < 64) log_addr[wr_count] <= addr;
                        wr_count <= wr_count + 1;
                    end
                end else begin
                    wait_q <= wait_q + 1;
                end
            end
        end
    end
endmodule

module wpol_cache_test;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // shared processor-side drive, routed to one instance by sel
    logic          sel = 1'b0;
    logic          req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;

    logic          a_stall, b_stall, a_mreq, b_mreq, a_mwe, b_mwe, a_ack, b_ack;
    logic          a_empty, b_empty, a_full, b_full;
    logic [DW-1:0] a_rdata, b_rdata, a_mwd, b_mwd, a_mrd, b_mrd;
    logic [AW-1:0] a_maddr, b_maddr;

    // write-back, allocate-on-write
    wpol_cache #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) uut (
        .clk(clk), .rst(rst), .cpu_req(req && !sel), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_rdata(a_rdata), .cpu_stall(a_stall),
        .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr), .mem_wdata(a_mwd),
        .mem_ack(a_ack), .mem_rdata(a_mrd), .wb_empty(a_empty), .wb_full(a_full));

    // write-through, no-allocate-on-write
    wpol_cache #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) uut_wt (
        .clk(clk), .rst(rst), .cpu_req(req && sel), .cpu_we(we), .cpu_addr(addr),
        .cpu_wdata(wdata), .cpu_rdata(b_rdata), .cpu_stall(b_stall),
        .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr), .mem_wdata(b_mwd),
        .mem_ack(b_ack), .mem_rdata(b_mrd), .wb_empty(b_empty), .wb_full(b_full));

    wpol_cache_memsim mem_a (.clk(clk), .rst(rst), .req(a_mreq), .we(a_mwe), .addr(a_maddr),
        .wdata(a_mwd), .ack(a_ack), .rdata(a_mrd));
    wpol_cache_memsim mem_b (.clk(clk), .rst(rst), .req(b_mreq), .we(b_mwe), .addr(b_maddr),
        .wdata(b_mwd), .ack(b_ack), .rdata(b_mrd));

    wire          stall = sel ? b_stall : a_stall;
    wire [DW-1:0] rdata = sel ? b_rdata : a_rdata;
    wire          wb_e  = sel ? b_empty : a_empty;
    wire          wb_f  = sel ? b_full  : a_full;
    wire          mreq  = sel ? b_mreq  : a_mreq;

    function automatic logic [DW-1:0] seed(input logic [AW-1:0] a);
        return DW'(a * 7 + 3);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] q, output int cyc, output bit saw_full);
        @(negedge clk);
        we = w; addr = a; wdata = d; req = 1'b1;
        cyc = 0; saw_full = 1'b0;
        #1;
        while (stall && cyc < 4000) begin
            if (wb_f) saw_full = 1'b1;
            @(negedge clk);
            #1;
            cyc++;
        end
        q = rdata;
        @(posedge clk);
        #1;
        req = 1'b0;
    endtask

    task automatic wait_drain();
        int n = 0;
        @(negedge clk);
        while (!(wb_e && !mreq) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    localparam logic [AW-1:0] A0 = 12'h040;
    localparam logic [AW-1:0] B0 = 12'h080;

    logic [DW-1:0] q;
    int cyc, wc0;
    bit sf;

    task automatic t_reset();
        @(negedge clk);
        chk(a_empty == 1'b1, "R12", "wb_empty after reset", 32'(a_empty), 1);
        chk(a_full == 1'b0, "R12", "wb_full after reset", 32'(a_full), 0);
        chk(a_stall == 1'b0, "R12", "stall idle", 32'(a_stall), 0);
        do_op(1'b0, A0, '0, q, cyc, sf);
        chk(cyc > 0, "R12", "first access misses", 32'(cyc), 1);
        chk(q == seed(A0), "R6", "read miss fill data", 32'(q), 32'(seed(A0)));
    endtask

    task automatic t_hit();
        do_op(1'b0, A0 + 1, '0, q, cyc, sf);
        chk(cyc == 0, "R1", "read hit cycles", 32'(cyc), 0);
        chk(q == seed(A0 + 1), "R1", "read hit data", 32'(q), 32'(seed(A0 + 1)));
    endtask

    task automatic t_wb_write_hit();
        wc0 = mem_a.wr_count;
        do_op(1'b1, A0 + 2, 16'hBEEF, q, cyc, sf);
        chk(cyc == 0, "R1", "write-back hit cycles", 32'(cyc), 0);
        @(negedge clk);
        chk(a_empty == 1'b1, "R4", "no buffer entry", 32'(a_empty), 1);
        repeat (10) @(negedge clk);
        chk(mem_a.wr_count == wc0, "R4", "no memory write", 32'(mem_a.wr_count), 32'(wc0));
        chk(mem_a.mem[A0 + 2] == seed(A0 + 2), "R4", "memory untouched",
            32'(mem_a.mem[A0 + 2]), 32'(seed(A0 + 2)));
        do_op(1'b0, A0 + 2, '0, q, cyc, sf);
        chk(q == 16'hBEEF && cyc == 0, "R4", "cached value", 32'(q), 32'hBEEF);
    endtask

    task automatic t_dirty_evict();
        wc0 = mem_a.wr_count;
        do_op(1'b0, A0 + 32, '0, q, cyc, sf);
        chk(q == seed(A0 + 32), "R6", "conflict fill data", 32'(q), 32'(seed(A0 + 32)));
        wait_drain();
        chk(mem_a.wr_count == wc0 + LW, "R5", "dirty victim words written",
            32'(mem_a.wr_count), 32'(wc0 + LW));
        chk(mem_a.mem[A0 + 2] == 16'hBEEF, "R5", "dirty word in memory",
            32'(mem_a.mem[A0 + 2]), 32'hBEEF);
    endtask

    task automatic t_clean_evict();
        wc0 = mem_a.wr_count;
        do_op(1'b0, A0 + 2, '0, q, cyc, sf);
        chk(q == 16'hBEEF, "R5", "refetch of written-back word", 32'(q), 32'hBEEF);
        wait_drain();
        chk(mem_a.wr_count == wc0, "R5", "clean victim no write", 32'(mem_a.wr_count), 32'(wc0));
    endtask

    task automatic t_write_alloc();
        wc0 = mem_a.wr_count;
        do_op(1'b1, 12'h141, 16'h7A7A, q, cyc, sf);
        chk(cyc > 0, "R6", "write miss fetches line", 32'(cyc), 1);
        do_op(1'b0, 12'h141, '0, q, cyc, sf);
        chk(q == 16'h7A7A && cyc == 0, "R6", "allocated write value", 32'(q), 32'h7A7A);
        do_op(1'b0, 12'h142, '0, q, cyc, sf);
        chk(q == seed(12'h142) && cyc == 0, "R6", "neighbour word fetched",
            32'(q), 32'(seed(12'h142)));
        wait_drain();
        chk(mem_a.wr_count == wc0, "R4", "allocated write stays in cache",
            32'(mem_a.wr_count), 32'(wc0));
    endtask

    task automatic t_nwa_then_read();
        do_op(1'b1, B0, 16'h1234, q, cyc, sf);
        chk(cyc == 0, "R7", "non-allocating write cycles", 32'(cyc), 0);
        chk(b_empty == 1'b0, "R7", "word buffered", 32'(b_empty), 0);
        do_op(1'b0, B0, '0, q, cyc, sf);
        chk(cyc > 0, "R7", "line not allocated by write", 32'(cyc), 1);
        chk(q == 16'h1234, "R8", "read after pending write", 32'(q), 32'h1234);
        do_op(1'b0, B0 + 1, '0, q, cyc, sf);
        chk(cyc == 0 && q == seed(B0 + 1), "R7", "read miss allocated", 32'(q), 32'(seed(B0 + 1)));
    endtask

    task automatic t_wt_write_hit();
        do_op(1'b1, B0 + 1, 16'h5555, q, cyc, sf);
        chk(cyc == 0, "R1", "write-through hit cycles", 32'(cyc), 0);
        chk(b_empty == 1'b0, "R2", "write-through word buffered", 32'(b_empty), 0);
        do_op(1'b0, B0 + 1, '0, q, cyc, sf);
        chk(q == 16'h5555 && cyc == 0, "R2", "cache updated", 32'(q), 32'h5555);
        wait_drain();
        chk(mem_b.mem[B0 + 1] == 16'h5555, "R2", "memory updated",
            32'(mem_b.mem[B0 + 1]), 32'h5555);
    endtask

    task automatic t_wt_victim();
        wc0 = mem_b.wr_count;
        do_op(1'b0, B0 + 32, '0, q, cyc, sf);
        chk(q == seed(B0 + 32), "R3", "replacement fill data", 32'(q), 32'(seed(B0 + 32)));
        wait_drain();
        chk(mem_b.wr_count == wc0, "R3", "no victim write", 32'(mem_b.wr_count), 32'(wc0));
    endtask

    task automatic t_full_and_order();
        bit any_full = 1'b0;
        bit any_stall = 1'b0;
        wc0 = mem_b.wr_count;
        for (int k = 0; k < 8; k++) begin
            do_op(1'b1, AW'(12'h200 + k), DW'(16'hA000 + k), q, cyc, sf);
            if (cyc > 0) any_stall = 1'b1;
            if (sf) any_full = 1'b1;
        end
        chk(any_full, "R9", "wb_full seen", 32'(any_full), 1);
        chk(any_stall, "R9", "write stalled on full buffer", 32'(any_stall), 1);
        wait_drain();
        for (int k = 0; k < 8; k++) begin
            chk(mem_b.log_addr[wc0 + k] == AW'(12'h200 + k), "R10", "drain order",
                32'(mem_b.log_addr[wc0 + k]), 32'(12'h200 + k));
            chk(mem_b.mem[12'h200 + k] == DW'(16'hA000 + k), "R10", "drained value",
                32'(mem_b.mem[12'h200 + k]), 32'(16'hA000 + k));
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        sel = 1'b0;
        t_reset();
        t_hit();
        t_wb_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_alloc();
        sel = 1'b1;
        t_nwa_then_read();
        t_wt_write_hit();
        t_wt_victim();
        t_full_and_order();
        chk(mem_a.hold_err == 0, "R11", "request hold (write-back)", 32'(mem_a.hold_err), 0);
        chk(mem_b.hold_err == 0, "R11", "request hold (write-through)", 32'(mem_b.hold_err), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule